// File: doc/BRIEF.md
# UART Channel Command and Status Unit

This block is the register core of one serial channel in a multi-channel UART. A host writes single bytes to a small set of register selects. It uses them to turn the receiver and transmitter on and off, to issue channel commands, to load the two mode registers and to hand characters to the transmitter. The serial receiver pushes assembled characters, their error flags and received break conditions into a three-entry circular holding FIFO. The host drains that FIFO through the holding register.

The unit keeps an 8-bit status register and drives three interrupt requests: transmitter ready, receiver ready and break. Break capture is tied to the FIFO read. A break stores a zero character and latches the break status bit. The break status bit is cleared, and the break interrupt raised, when the host reads the holding register while the bit is set. The baud generator, serialiser, deserialiser and parity logic sit outside this unit. Writes to the clock-select, auxiliary and output-port selects are accepted and dropped.

Within one cycle the unit applies events in a fixed order: the low enable and disable bits of a command, then its command code, then the host holding-register read, then the receiver push or break.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, all three interrupt requests and `tx_valid` are low, `rx_space` is 0 (receiver disabled), and both mode registers read 0.
- R2: A byte written to select 2 (command) enables the receiver when bit 0 is set and disables it when bit 1 is set; with both set the receiver ends disabled. `rx_space` reports the free FIFO entries while enabled and 0 while disabled.
- R3: Command bit 2 sets status bits 2 (transmit ready) and 3 (transmitter empty) and raises `irq_txrdy`. Command bit 3, or command code 3 in bits 7:4, clears all three.
- R4: Select 0 reaches two mode registers through a pointer. After reset or command code 1, the first read or write goes to the first mode register, and every later access goes to the second one.
- R5: The FIFO holds up to 3 characters and returns them in arrival order, including across the wrap of its circular storage. Each holding-register read (select 3) of a nonempty FIFO removes the head.
- R6: Status bit 0 and `irq_rxrdy` rise with the first character accepted into an empty FIFO and fall when the read that empties it completes. A read of an empty FIFO changes nothing.
- R7: Characters and breaks arriving while the receiver is disabled are not stored.
- R8: A character arriving while the FIFO holds 3 is discarded and sets status bit 4 (overrun). The stored characters are unchanged.
- R9: Command code 2 disables the receiver, empties the FIFO and clears status bit 0 and `irq_rxrdy`.
- R10: A stored character with `rx_perr` or `rx_ferr` sets status bit 5 or bit 6. Command code 4 clears status bits 4 to 7.
- R11: A received break sets status bit 7 and `irq_break` only when bit 7 was clear, and it stores a 0x00 character. Command code 5 clears `irq_break`.
- R12: A holding-register read of a nonempty FIFO while status bit 7 is set clears bit 7 and raises `irq_break`.
- R13: A byte written to select 3 appears on `tx_data` with a one-cycle `tx_valid` pulse in the next cycle only when status bit 2 is set; otherwise it is dropped.
- R14: Writes to select 1 (clock select), select 4 (auxiliary) and select 5 (output port), and command codes 6 to 15, change no status bit, interrupt, FIFO content or mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 3 | Read register select |
| rd_data | output | DATA_W | Read data, combinational while rd_en is high |
| rx_valid | input | 1 | Receiver character strobe |
| rx_data | input | DATA_W | Received character |
| rx_perr | input | 1 | Parity error flag for rx_data |
| rx_ferr | input | 1 | Framing error flag for rx_data |
| rx_break | input | 1 | Received break condition strobe |
| rx_space | output | CNT_W | Free FIFO entries, 0 while the receiver is disabled |
| tx_valid | output | 1 | Character-to-transmitter strobe |
| tx_data | output | DATA_W | Character to transmitter |
| status | output | 8 | Status byte |
| irq_txrdy | output | 1 | Transmit-ready interrupt request |
| irq_rxrdy | output | 1 | Receive-ready interrupt request |
| irq_break | output | 1 | Break interrupt request |

## Verification
The bench refills the FIFO across the wrap of its circular storage. A pointer that advanced on the final read, or a write position taken from the old read pointer, would return stale or reordered characters there. It pushes a fourth character into a full FIFO, where a wrong full test would overwrite the head or miss the overrun flag. It sends two breaks back to back, where a design without the interlock would re-raise the break interrupt or fail to defer it until the zero character is read. It also checks that the mode pointer stays on the second register and that a byte written to the transmit register is dropped while the transmitter is off.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    localparam int ST_W = 8;

    // status bit positions
    localparam int ST_RXRDY = 0;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMT = 3;
    localparam int ST_OVR   = 4;
    localparam int ST_PAR   = 5;
    localparam int ST_FRM   = 6;
    localparam int ST_BRK   = 7;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_CMD   = 3'd2,
        SEL_HOLD  = 3'd3,
        SEL_AUX   = 3'd4,
        SEL_OPORT = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_RSV7  = 3'd7
    } reg_sel_e;

    localparam logic [3:0] CMD_NOP     = 4'd0;
    localparam logic [3:0] CMD_PTR_RST = 4'd1;
    localparam logic [3:0] CMD_RX_RST  = 4'd2;
    localparam logic [3:0] CMD_TX_RST  = 4'd3;
    localparam logic [3:0] CMD_ERR_CLR = 4'd4;
    localparam logic [3:0] CMD_BRK_CLR = 4'd5;

    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_clr;
        logic brk_clr;
    } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_chan_pkg::*;
(
    input  logic       strobe,
    input  logic [7:0] cmd_byte,
    output cmd_act_t   act
);

    always_comb begin
        act = '0;
        if (strobe) begin
            act.rx_on  = cmd_byte[0];
            act.rx_off = cmd_byte[1];
            act.tx_on  = cmd_byte[2];
            act.tx_off = cmd_byte[3];
            case (cmd_byte[7:4])
                CMD_PTR_RST: act.ptr_rst = 1'b1;
                CMD_RX_RST:  act.rx_rst  = 1'b1;
                CMD_TX_RST:  act.tx_rst  = 1'b1;
                CMD_ERR_CLR: act.err_clr = 1'b1;
                CMD_BRK_CLR: act.brk_clr = 1'b1;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              accepted,
    output logic              overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SUM_W = $clog2(2 * DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic             pop_ok;
    logic [PTR_W-1:0] rd_n;
    logic [CNT_W-1:0] cnt_p;
    logic [SUM_W-1:0] wsum;
    logic [PTR_W-1:0] wpos;

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && !flush && (st_q.cnt != '0);
        rd_n   = st_q.rd;
        cnt_p  = st_q.cnt;
        if (pop_ok) begin
            cnt_p = st_q.cnt - 1'b1;
            // the pointer stays on the last slot when the FIFO drains
            if (st_q.cnt != CNT_W'(1))
                rd_n = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        // free slot follows the post-pop head
        wsum = SUM_W'(rd_n) + SUM_W'(cnt_p);
        if (wsum >= SUM_W'(DEPTH))
            wsum = wsum - SUM_W'(DEPTH);
        wpos     = PTR_W'(wsum);
        accepted = push && !flush && (cnt_p < CNT_W'(DEPTH));
        overflow = push && !flush && (cnt_p == CNT_W'(DEPTH));
        if (accepted) begin
            st_d.mem[wpos] = push_data;
            cnt_p          = cnt_p + 1'b1;
        end
        st_d.rd  = rd_n;
        st_d.cnt = flush ? '0 : cnt_p;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));

    a_r5_pop_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import uart_chan_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 3,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_break,
    output logic [CNT_W-1:0]  rx_space,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [ST_W-1:0]   status,
    output logic              irq_txrdy,
    output logic              irq_rxrdy,
    output logic              irq_break
);

    typedef struct packed {
        logic [ST_W-1:0]          sr;
        logic                     rx_en;
        logic                     mr_ptr;
        logic [1:0][DATA_W-1:0]   mr;
        logic                     irq_tx;
        logic                     irq_rx;
        logic                     irq_brk;
        logic                     tx_vld;
        logic [DATA_W-1:0]        tx_dat;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    cmd_act_t          act;
    reg_sel_e          wsel, rsel;
    logic              fifo_push, fifo_pop, fifo_acc, fifo_ovf;
    logic [DATA_W-1:0] fifo_in, fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              pop_ok;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    uart_cmd_decode u_dec (
        .strobe   (wr_en && (wsel == SEL_CMD)),
        .cmd_byte (wr_data[7:0]),
        .act      (act)
    );

    assign fifo_push = (rx_valid || rx_break) && st_q.rx_en;
    assign fifo_in   = rx_break ? '0 : rx_data;
    assign fifo_pop  = rd_en && (rsel == SEL_HOLD);
    assign pop_ok    = fifo_pop && (fifo_cnt != '0) && !act.rx_rst;

    uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_in),
        .pop       (fifo_pop),
        .flush     (act.rx_rst),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .accepted  (fifo_acc),
        .overflow  (fifo_ovf)
    );

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;

        // mode-register port: any access leaves the pointer on the second register
        if (wr_en && (wsel == SEL_MODE)) begin
            st_d.mr[st_q.mr_ptr] = wr_data;
            st_d.mr_ptr          = 1'b1;
        end
        if (rd_en && (rsel == SEL_MODE))
            st_d.mr_ptr = 1'b1;

        // low command bits act before the command code
        if (act.rx_on)  st_d.rx_en = 1'b1;
        if (act.rx_off) st_d.rx_en = 1'b0;
        if (act.tx_on) begin
            st_d.sr[ST_TXRDY] = 1'b1;
            st_d.sr[ST_TXEMT] = 1'b1;
            st_d.irq_tx       = 1'b1;
        end
        if (act.tx_off || act.tx_rst) begin
            st_d.sr[ST_TXRDY] = 1'b0;
            st_d.sr[ST_TXEMT] = 1'b0;
            st_d.irq_tx       = 1'b0;
        end
        if (act.ptr_rst) st_d.mr_ptr = 1'b0;
        if (act.rx_rst) begin
            st_d.rx_en        = 1'b0;
            st_d.sr[ST_RXRDY] = 1'b0;
            st_d.irq_rx       = 1'b0;
        end
        if (act.err_clr) st_d.sr[ST_BRK:ST_OVR] = '0;
        if (act.brk_clr) st_d.irq_brk = 1'b0;

        // transmit holding register
        if (wr_en && (wsel == SEL_HOLD) && st_q.sr[ST_TXRDY]) begin
            st_d.tx_vld = 1'b1;
            st_d.tx_dat = wr_data;
        end

        // host read of the receive holding register
        if (pop_ok) begin
            if (fifo_cnt == CNT_W'(1) && !fifo_acc) begin
                st_d.sr[ST_RXRDY] = 1'b0;
                st_d.irq_rx       = 1'b0;
            end
            if (st_q.sr[ST_BRK]) begin
                st_d.sr[ST_BRK] = 1'b0;
                st_d.irq_brk    = 1'b1;
            end
        end

        // receiver side
        if (rx_break && !st_q.sr[ST_BRK]) begin
            st_d.sr[ST_BRK] = 1'b1;
            st_d.irq_brk    = 1'b1;
        end
        if (fifo_acc) begin
            st_d.sr[ST_RXRDY] = 1'b1;
            st_d.irq_rx       = 1'b1;
            if (!rx_break) begin
                if (rx_perr) st_d.sr[ST_PAR] = 1'b1;
                if (rx_ferr) st_d.sr[ST_FRM] = 1'b1;
            end
        end
        if (fifo_ovf) st_d.sr[ST_OVR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rsel)
                SEL_MODE: rd_data = st_q.mr[st_q.mr_ptr];
                SEL_STAT: rd_data = DATA_W'(st_q.sr);
                SEL_HOLD: rd_data = fifo_head;
                default:  rd_data = '0;
            endcase
        end
    end

    assign rx_space  = st_q.rx_en ? (CNT_W'(FIFO_DEPTH) - fifo_cnt) : '0;
    assign tx_valid  = st_q.tx_vld;
    assign tx_data   = st_q.tx_dat;
    assign status    = st_q.sr;
    assign irq_txrdy = st_q.irq_tx;
    assign irq_rxrdy = st_q.irq_rx;
    assign irq_break = st_q.irq_brk;

    a_r6_rxrdy_tracks_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr[ST_RXRDY] == (fifo_cnt != '0));

    a_r3_tx_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq_tx == st_q.sr[ST_TXRDY]) && (st_q.sr[ST_TXRDY] == st_q.sr[ST_TXEMT]));

    a_r13_tx_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tx_vld |-> $past(st_q.sr[ST_TXRDY]));

    a_r7_no_store_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.rx_en && !fifo_pop && !act.rx_rst) |=> (fifo_cnt == $past(fifo_cnt)));

endmodule

// File: tb/uart_chan_ctrl_test.sv
`timescale 1ns/1ps
module uart_chan_ctrl_test;

    localparam logic [2:0] S_MODE = 3'd0, S_STAT = 3'd1, S_CMD = 3'd2,
                           S_HOLD = 3'd3, S_AUX = 3'd4, S_OPORT = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] wr_data = '0, rx_data = '0;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_break = 1'b0;
    logic [7:0] rd_data, tx_data, status;
    logic [1:0] rx_space;
    logic       tx_valid, irq_txrdy, irq_rxrdy, irq_break;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_break(rx_break), .rx_space(rx_space),
        .tx_valid(tx_valid), .tx_data(tx_data), .status(status),
        .irq_txrdy(irq_txrdy), .irq_rxrdy(irq_rxrdy), .irq_break(irq_break)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] sel, output logic [7:0] val);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        #1 val = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rx_char(input logic [7:0] val, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = val; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic rx_brk();
        @(negedge clk);
        rx_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    task automatic fresh_rx();
        host_wr(S_CMD, 8'h20);
        host_wr(S_CMD, 8'h40);
        host_wr(S_CMD, 8'h50);
        host_wr(S_CMD, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "status", status, 8'h00);
        chk("R1", "irqs", {irq_txrdy, irq_rxrdy, irq_break}, 3'b000);
        chk("R1", "rx_space", rx_space, 2'd0);
        chk("R1", "tx_valid", tx_valid, 1'b0);
        host_rd(S_MODE, v);
        chk("R1", "mode reg", v, 8'h00);
    endtask

    task automatic t_rx_enable();
        host_wr(S_CMD, 8'h01);
        chk("R2", "space after enable", rx_space, 2'd3);
        host_wr(S_CMD, 8'h03);
        chk("R2", "space after on+off", rx_space, 2'd0);
        host_wr(S_CMD, 8'h01);
        host_wr(S_CMD, 8'h02);
        chk("R2", "space after disable", rx_space, 2'd0);
    endtask

    task automatic t_tx();
        host_wr(S_HOLD, 8'h55);
        chk("R13", "tx dropped while off", tx_valid, 1'b0);
        host_wr(S_CMD, 8'h04);
        chk("R3", "tx bits after enable", status[3:2], 2'b11);
        chk("R3", "irq_txrdy after enable", irq_txrdy, 1'b1);
        host_wr(S_HOLD, 8'hA5);
        chk("R13", "tx_valid", tx_valid, 1'b1);
        chk("R13", "tx_data", tx_data, 8'hA5);
        @(negedge clk);
        chk("R13", "tx_valid one cycle", tx_valid, 1'b0);
        host_wr(S_CMD, 8'h08);
        chk("R3", "tx bits after disable", {status[3:2], irq_txrdy}, 3'b000);
        host_wr(S_CMD, 8'h04);
        host_wr(S_CMD, 8'h30);
        chk("R3", "tx bits after reset cmd", {status[3:2], irq_txrdy}, 3'b000);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        host_wr(S_CMD, 8'h10);
        host_wr(S_MODE, 8'h11);
        host_wr(S_MODE, 8'h22);
        host_wr(S_MODE, 8'h33);
        host_wr(S_CMD, 8'h10);
        host_rd(S_MODE, v);
        chk("R4", "first access MR1", v, 8'h11);
        host_rd(S_MODE, v);
        chk("R4", "second access MR2", v, 8'h33);
        host_rd(S_MODE, v);
        chk("R4", "pointer stays MR2", v, 8'h33);
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        fresh_rx();
        rx_char(8'hA1, 0, 0);
        chk("R6", "rxrdy on first byte", {status[0], irq_rxrdy}, 2'b11);
        chk("R5", "space 2", rx_space, 2'd2);
        rx_char(8'hB2, 0, 0);
        rx_char(8'hC3, 0, 0);
        chk("R5", "space full", rx_space, 2'd0);
        host_rd(S_HOLD, v); chk("R5", "order 1", v, 8'hA1);
        host_rd(S_HOLD, v); chk("R5", "order 2", v, 8'hB2);
        chk("R6", "rxrdy held", status[0], 1'b1);
        host_rd(S_HOLD, v); chk("R5", "order 3", v, 8'hC3);
        chk("R6", "rxrdy cleared", {status[0], irq_rxrdy}, 2'b00);
        host_rd(S_HOLD, v);
        chk("R6", "empty read no change", {status[0], irq_rxrdy, rx_space}, 4'b0011);
        rx_char(8'hD4, 0, 0);
        rx_char(8'hE5, 0, 0);
        host_rd(S_HOLD, v); chk("R5", "wrap 1", v, 8'hD4);
        rx_char(8'hF6, 0, 0);
        rx_char(8'h07, 0, 0);
        chk("R5", "wrap full", rx_space, 2'd0);
        host_rd(S_HOLD, v); chk("R5", "wrap 2", v, 8'hE5);
        host_rd(S_HOLD, v); chk("R5", "wrap 3", v, 8'hF6);
        host_rd(S_HOLD, v); chk("R5", "wrap 4", v, 8'h07);
    endtask

    task automatic t_disabled();
        host_wr(S_CMD, 8'h02);
        rx_char(8'h77, 0, 0);
        rx_brk();
        host_wr(S_CMD, 8'h01);
        chk("R7", "nothing stored while off", {status[0], rx_space}, 3'b011);
        host_wr(S_CMD, 8'h40);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        fresh_rx();
        rx_char(8'h10, 0, 0);
        rx_char(8'h20, 0, 0);
        rx_char(8'h30, 0, 0);
        rx_char(8'h40, 1, 1);
        chk("R8", "overrun bit", status[4], 1'b1);
        chk("R8", "no error from dropped byte", status[6:5], 2'b00);
        host_rd(S_HOLD, v); chk("R8", "content 1", v, 8'h10);
        host_rd(S_HOLD, v); chk("R8", "content 2", v, 8'h20);
        host_rd(S_HOLD, v); chk("R8", "content 3", v, 8'h30);
        chk("R8", "drained", rx_space, 2'd3);
        rx_char(8'h01, 1, 0);
        chk("R10", "parity bit", status[5], 1'b1);
        rx_char(8'h02, 0, 1);
        chk("R10", "framing bit", status[6], 1'b1);
        host_wr(S_CMD, 8'h40);
        chk("R10", "errors cleared", status[7:4], 4'h0);
        host_rd(S_HOLD, v);
        host_rd(S_HOLD, v);
    endtask

    task automatic t_reset_rx();
        fresh_rx();
        rx_char(8'h5A, 0, 0);
        rx_char(8'h6B, 0, 0);
        host_wr(S_CMD, 8'h20);
        chk("R9", "rxrdy and irq cleared", {status[0], irq_rxrdy}, 2'b00);
        chk("R9", "receiver off", rx_space, 2'd0);
        host_wr(S_CMD, 8'h01);
        chk("R9", "fifo empty", rx_space, 2'd3);
    endtask

    task automatic t_break();
        logic [7:0] v;
        fresh_rx();
        rx_brk();
        chk("R11", "break bit", status[7], 1'b1);
        chk("R11", "break irq", irq_break, 1'b1);
        chk("R11", "zero char stored", {status[0], rx_space}, 3'b110);
        host_wr(S_CMD, 8'h50);
        chk("R11", "break irq cleared", irq_break, 1'b0);
        chk("R11", "break bit kept", status[7], 1'b1);
        rx_brk();
        chk("R11", "no second irq", irq_break, 1'b0);
        chk("R11", "second zero char", rx_space, 2'd1);
        host_rd(S_HOLD, v);
        chk("R11", "zero char value", v, 8'h00);
        chk("R12", "break bit cleared on read", status[7], 1'b0);
        chk("R12", "break irq on read", irq_break, 1'b1);
        host_rd(S_HOLD, v);
        chk("R12", "second read", {v, status[7], irq_break}, {8'h00, 1'b0, 1'b1});
        host_wr(S_CMD, 8'h50);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        logic [7:0] st0;
        fresh_rx();
        host_wr(S_CMD, 8'h04);
        rx_char(8'h99, 0, 0);
        st0 = status;
        host_wr(S_STAT, 8'hFF);
        host_wr(S_AUX, 8'hFF);
        host_wr(S_OPORT, 8'hFF);
        host_wr(S_CMD, 8'h60);
        host_wr(S_CMD, 8'hF0);
        chk("R14", "status unchanged", status, st0);
        chk("R14", "irqs unchanged", {irq_txrdy, irq_rxrdy, irq_break}, 3'b110);
        chk("R14", "space unchanged", rx_space, 2'd2);
        host_rd(S_MODE, v);
        chk("R14", "mode reg unchanged", v, 8'h33);
        host_rd(S_HOLD, v);
        chk("R14", "fifo content unchanged", v, 8'h99);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_enable();
        t_tx();
        t_mode();
        t_fifo();
        t_disabled();
        t_overrun();
        t_reset_rx();
        t_break();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule